// File: doc/BRIEF.md
# Boot-Block Flash Command Sequencer

This block is the command front end of a parallel NOR flash that has eleven erase blocks, one of which is a protected boot block. A host drives 8-bit commands on the low byte of the write data bus. Two-write sequences arm and then start a word program or a block erase. While the operation runs, a short internal busy counter stands in for the slow array work. A small behavioural memory keeps a few words per block so that the effect of each operation can be seen on the read port.

Every program or erase is checked against a valid-program-voltage input. When it targets the boot block, it is also checked against the boot-unlock input and the write-protect-release input. The block keeps an 8-bit status byte and picks which source the combinational read port shows: array data, status, or identification codes. A parameter selects where the boot block sits, either at the bottom or at the top of the word address space. The rest of the block map follows from that choice.

Top module: `bbf_cmd_ctrl`

## Requirements
- R1: After reset the read port shows array data, and the status byte reads 0x80: bit 7 ready = 1, all error bits clear.
- R2: Block map, bottom-boot form. The boot block covers words 00000h-01FFFh, the parameter blocks 02000h-02FFFh and 03000h-03FFFh, and the small main block 04000h-0FFFFh; each further 64K-word region is one block. The top-boot form is the mirror image, so 7E000h-7FFFFh is the boot block. An erase changes only its own block.
- R3: Writing 10h or 40h, then a data write, programs that address once the operation finishes. The new word is the old word AND the data. FFh returns the read port to array data.
- R4: Writing 20h, then D0h with a valid program voltage, sets every word of the addressed block to all ones.
- R5: When a program or erase finishes, the read port shows status and keeps showing it until FFh is written.
- R6: A program or erase of the boot block runs only if boot_unlock or wp_release is high at the second write. Otherwise status bit 4 (program) or bit 5 (erase) is set and memory is unchanged.
- R7: If vpp_ok is low at the second write, status bit 3 is set together with bit 4 (program) or bit 5 (erase), and memory is unchanged.
- R8: An erase setup followed by any value other than D0h sets status bits 5 and 4 and erases nothing.
- R9: Error bits stay set until a 50h write clears them.
- R10: 70h selects status. The upper data bits read zero and the status byte sits in bits 7:0. 90h selects identification: address bit 0 = 0 gives MFG_ID and = 1 gives DEV_ID. Unknown command values change nothing.
- R11: Status bit 7 reads 0 for exactly BUSY_CYCLES cycles after the second write, and bus writes during that time are ignored.
- R12: Reset clears the error bits and selects array reads, but memory contents survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | 19 | Word address for reads and writes |
| bus_wdata | input | 16 | Write data; bits 7:0 carry commands |
| boot_unlock | input | 1 | Boot block unlock (high-voltage reset level present) |
| wp_release | input | 1 | Write-protect released, boot block writable |
| vpp_ok | input | 1 | Program voltage valid |
| rd_data | output | 16 | Read data from the selected source |

## Verification
The assertions assume that bus_we is a single-cycle synchronous strobe. They sample vpp_ok, boot_unlock and wp_release at the edge that takes the second write of a sequence. They also assume the read address stays stable for the cycle that follows a completed operation. The stimulus respects all of this: it changes the protection and voltage inputs only at falling edges between sequences, never while an operation is busy, and it reads only after the write strobe has dropped.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
   localparam int unsigned NUM_BLOCKS = 11;
   localparam int unsigned BLK_W      = 4;

   typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} rd_src_e;
   typedef enum logic [1:0] {SQ_IDLE, SQ_ERASE_ARM, SQ_PROG_ARM, SQ_BUSY} sq_state_e;
   typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} arr_op_e;

   localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
   localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
   localparam logic [7:0] CMD_PROG_A     = 8'h10;
   localparam logic [7:0] CMD_PROG_B     = 8'h40;
   localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_STATUS     = 8'h70;
   localparam logic [7:0] CMD_IDENT      = 8'h90;
   localparam logic [7:0] CMD_CLR_ERR    = 8'h50;

   // error vector layout inside the sequencer
   localparam int unsigned ERR_VPP   = 0;
   localparam int unsigned ERR_PROG  = 1;
   localparam int unsigned ERR_ERASE = 2;
endpackage

// File: rtl/bbf_block_map.sv
module bbf_block_map
   import bbf_pkg::*;
#(
   parameter int unsigned ADDR_W   = 19,
   parameter bit          TOP_BOOT = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BLK_W-1:0]  blk,
   output logic              is_boot
);
   localparam logic [ADDR_W-1:0] BOOT_WORDS  = ADDR_W'(1) << (ADDR_W - 6);
   localparam logic [ADDR_W-1:0] PARAM_WORDS = ADDR_W'(1) << (ADDR_W - 7);
   localparam logic [ADDR_W-1:0] REGION      = ADDR_W'(1) << (ADDR_W - 3);
   localparam logic [ADDR_W-1:0] PARAM0_END  = BOOT_WORDS + PARAM_WORDS;
   localparam logic [ADDR_W-1:0] PARAM1_END  = BOOT_WORDS + 2 * PARAM_WORDS;
   localparam logic [BLK_W-1:0]  LAST_BLK    = BLK_W'(NUM_BLOCKS - 1);

   logic [ADDR_W-1:0] m_addr;
   logic [BLK_W-1:0]  idx;

   // top-boot layout is the bit-inverted image of the bottom-boot layout
   generate
      if (TOP_BOOT) begin : g_top
         assign m_addr = ~addr;
         assign blk    = LAST_BLK - idx;
      end else begin : g_bottom
         assign m_addr = addr;
         assign blk    = idx;
      end
   endgenerate

   always_comb begin
      if (m_addr < BOOT_WORDS)      idx = BLK_W'(0);
      else if (m_addr < PARAM0_END) idx = BLK_W'(1);
      else if (m_addr < PARAM1_END) idx = BLK_W'(2);
      else if (m_addr < REGION)     idx = BLK_W'(3);
      else                          idx = BLK_W'(3) + BLK_W'(m_addr[ADDR_W-1 -: 3]);
   end

   assign is_boot = (idx == BLK_W'(0));

   if (ADDR_W < 8) begin : g_chk_addr
      $error("bbf_block_map: ADDR_W too small for the block layout");
   end
endmodule

// File: rtl/bbf_array.sv
module bbf_array
   import bbf_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SLOT_W = 2
) (
   input  logic              clk,
   input  arr_op_e           op,
   input  logic [BLK_W-1:0]  op_blk,
   input  logic [SLOT_W-1:0] op_slot,
   input  logic [DATA_W-1:0] op_data,
   input  logic [BLK_W-1:0]  rd_blk,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned SLOTS = 1 << SLOT_W;
   localparam int unsigned DEPTH = 1 << (BLK_W + SLOT_W);

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '1;
   end

   always_ff @(posedge clk) begin
      case (op)
         OP_PROG:  mem[{op_blk, op_slot}] <= mem[{op_blk, op_slot}] & op_data;
         OP_ERASE: begin
            for (int s = 0; s < SLOTS; s++) mem[{op_blk, SLOT_W'(s)}] <= '1;
         end
         default: ;
      endcase
   end

   assign rd_word = mem[{rd_blk, rd_slot}];

   if (SLOT_W < 1 || SLOT_W > 6) begin : g_chk_slot
      $error("bbf_array: SLOT_W out of range");
   end
endmodule

// File: rtl/bbf_cmd_seq.sv
module bbf_cmd_seq
   import bbf_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SLOT_W      = 2,
   parameter int unsigned BUSY_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [SLOT_W-1:0] bus_slot,
   input  logic [BLK_W-1:0]  cur_blk,
   input  logic              cur_boot,
   input  logic              boot_unlock,
   input  logic              wp_release,
   input  logic              vpp_ok,
   output rd_src_e           rd_src,
   output logic [7:0]        status,
   output arr_op_e           op,
   output logic [BLK_W-1:0]  op_blk,
   output logic [SLOT_W-1:0] op_slot,
   output logic [DATA_W-1:0] op_data
);
   localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   sq_state_e         state_q;
   rd_src_e           src_q;
   logic [2:0]        err_q;
   logic [CNT_W-1:0]  cnt_q;
   arr_op_e           kind_q;
   logic [BLK_W-1:0]  blk_q;
   logic [SLOT_W-1:0] slot_q;
   logic [DATA_W-1:0] data_q;

   logic [7:0] cmd;
   logic       boot_open;
   logic       clr_hit;

   assign cmd       = bus_wdata[7:0];
   assign boot_open = boot_unlock | wp_release;
   assign clr_hit   = (state_q == SQ_IDLE) && bus_we && (cmd == CMD_CLR_ERR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         src_q   <= RD_ARRAY;
         err_q   <= '0;
         cnt_q   <= '0;
         kind_q  <= OP_NONE;
         blk_q   <= '0;
         slot_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (bus_we) begin
                  case (cmd)
                     CMD_ERASE_ARM:          state_q <= SQ_ERASE_ARM;
                     CMD_PROG_A, CMD_PROG_B: state_q <= SQ_PROG_ARM;
                     CMD_READ_ARRAY:         src_q   <= RD_ARRAY;
                     CMD_STATUS:             src_q   <= RD_STATUS;
                     CMD_IDENT:              src_q   <= RD_IDENT;
                     CMD_CLR_ERR:            err_q   <= '0;
                     default: ;
                  endcase
               end
            end
            SQ_ERASE_ARM: begin
               if (bus_we) begin
                  src_q   <= RD_STATUS;
                  state_q <= SQ_IDLE;
                  if (cmd != CMD_CONFIRM) begin
                     err_q[ERR_ERASE] <= 1'b1;
                     err_q[ERR_PROG]  <= 1'b1;
                  end else if (!vpp_ok) begin
                     err_q[ERR_ERASE] <= 1'b1;
                     err_q[ERR_VPP]   <= 1'b1;
                  end else if (cur_boot && !boot_open) begin
                     err_q[ERR_ERASE] <= 1'b1;
                  end else begin
                     state_q <= SQ_BUSY;
                     cnt_q   <= CNT_LOAD;
                     kind_q  <= OP_ERASE;
                     blk_q   <= cur_blk;
                  end
               end
            end
            SQ_PROG_ARM: begin
               if (bus_we) begin
                  src_q   <= RD_STATUS;
                  state_q <= SQ_IDLE;
                  if (!vpp_ok) begin
                     err_q[ERR_PROG] <= 1'b1;
                     err_q[ERR_VPP]  <= 1'b1;
                  end else if (cur_boot && !boot_open) begin
                     err_q[ERR_PROG] <= 1'b1;
                  end else begin
                     state_q <= SQ_BUSY;
                     cnt_q   <= CNT_LOAD;
                     kind_q  <= OP_PROG;
                     blk_q   <= cur_blk;
                     slot_q  <= bus_slot;
                     data_q  <= bus_wdata;
                  end
               end
            end
            SQ_BUSY: begin
               cnt_q <= cnt_q - CNT_LAST;
               if (cnt_q == CNT_LAST) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign rd_src  = src_q;
   assign status  = {state_q != SQ_BUSY, 1'b0, err_q, 3'b000};
   assign op      = (state_q == SQ_BUSY && cnt_q == CNT_LAST) ? kind_q : OP_NONE;
   assign op_blk  = blk_q;
   assign op_slot = slot_q;
   assign op_data = data_q;

   if (BUSY_CYCLES < 1) begin : g_chk_busy
      $error("bbf_cmd_seq: BUSY_CYCLES must be at least 1");
   end

   // R7: an operation only starts if the program voltage was valid at the second write
   assert_start_needs_vpp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_BUSY && $past(state_q) != SQ_BUSY) |-> $past(vpp_ok));

   // R6: boot block operations only start when unlocked
   assert_boot_start_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_BUSY && $past(state_q) != SQ_BUSY && $past(cur_boot))
         |-> $past(boot_unlock || wp_release));

   // R9: error bits never drop without a clear command
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit |=> ((err_q & $past(err_q)) == $past(err_q)));

   // R5: the cycle after an operation finishes, status is selected
   assert_done_shows_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_NONE) |=> (src_q == RD_STATUS));

   // R11: bus writes while busy change neither source nor errors
   assert_busy_ignores_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_BUSY) |=> ($stable(src_q) && $stable(err_q)));

   // R11: busy holds until the counter runs out
   assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_BUSY && cnt_q > CNT_LAST) |=> (state_q == SQ_BUSY));

   // R12: leaving reset gives array reads and no errors
   assert_reset_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (src_q == RD_ARRAY && err_q == 3'b000));
endmodule

// File: rtl/bbf_cmd_ctrl.sv
module bbf_cmd_ctrl
   import bbf_pkg::*;
#(
   parameter int unsigned ADDR_W      = 19,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SLOT_W      = 2,
   parameter int unsigned BUSY_CYCLES = 4,
   parameter bit          TOP_BOOT    = 1'b0,
   parameter logic [DATA_W-1:0] MFG_ID = 16'h00A7,
   parameter logic [DATA_W-1:0] DEV_ID = 16'h5B31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              boot_unlock,
   input  logic              wp_release,
   input  logic              vpp_ok,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned PAD_W = DATA_W - 8;

   logic [BLK_W-1:0]  cur_blk;
   logic              cur_boot;
   rd_src_e           rd_src;
   logic [7:0]        status;
   arr_op_e           op;
   logic [BLK_W-1:0]  op_blk;
   logic [SLOT_W-1:0] op_slot;
   logic [DATA_W-1:0] op_data;
   logic [DATA_W-1:0] arr_word;

   bbf_block_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) map_i (
      .addr    (bus_addr),
      .blk     (cur_blk),
      .is_boot (cur_boot)
   );

   bbf_cmd_seq #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .BUSY_CYCLES(BUSY_CYCLES)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_wdata   (bus_wdata),
      .bus_slot    (bus_addr[SLOT_W-1:0]),
      .cur_blk     (cur_blk),
      .cur_boot    (cur_boot),
      .boot_unlock (boot_unlock),
      .wp_release  (wp_release),
      .vpp_ok      (vpp_ok),
      .rd_src      (rd_src),
      .status      (status),
      .op          (op),
      .op_blk      (op_blk),
      .op_slot     (op_slot),
      .op_data     (op_data)
   );

   bbf_array #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) array_i (
      .clk     (clk),
      .op      (op),
      .op_blk  (op_blk),
      .op_slot (op_slot),
      .op_data (op_data),
      .rd_blk  (cur_blk),
      .rd_slot (bus_addr[SLOT_W-1:0]),
      .rd_word (arr_word)
   );

   always_comb begin
      case (rd_src)
         RD_STATUS: rd_data = {{PAD_W{1'b0}}, status};
         RD_IDENT:  rd_data = bus_addr[0] ? DEV_ID : MFG_ID;
         default:   rd_data = arr_word;
      endcase
   end

   if (DATA_W < 9) begin : g_chk_data
      $error("bbf_cmd_ctrl: DATA_W must exceed the 8-bit command width");
   end
   if (SLOT_W >= ADDR_W) begin : g_chk_slot
      $error("bbf_cmd_ctrl: SLOT_W must be below ADDR_W");
   end

   // R4: after an erase, any word read from the erased block is all ones
   assert_erase_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ERASE) |=> (cur_blk != $past(op_blk) || arr_word == '1));

   // R3: a programmed word holds no one where the program data had a zero
   assert_prog_clears_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PROG) |=> (cur_blk != $past(op_blk) ||
                           bus_addr[SLOT_W-1:0] != $past(op_slot) ||
                           (arr_word & ~$past(op_data)) == '0));

   // R10: status reads carry zeros above the status byte
   assert_status_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src == RD_STATUS) |-> (rd_data[DATA_W-1:8] == '0));
endmodule

// File: tb/bbf_cmd_ctrl_tb.sv
module bbf_cmd_ctrl_tb_top;
   localparam logic [15:0] MFG   = 16'h00A7;
   localparam logic [15:0] DEV_B = 16'h5B31;
   localparam logic [15:0] DEV_T = 16'h5B30;
   localparam int BUSY = 4;

   localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WT = 2'd2;
   // entry: kind[43:42] ctl{vpp,unlock,wp}[41:39] addr[38:20] data[19:4] req[3:0]
   localparam int NV = 69;
   localparam logic [43:0] TBL [NV] = '{
      {K_RD, 3'b100, 19'h10000, 16'hFFFF, 4'd1},   // R1 array read after reset
      {K_WR, 3'b100, 19'h10001, 16'h0040, 4'd3},   // R3 program setup
      {K_WR, 3'b100, 19'h10001, 16'h12F0, 4'd3},
      {K_RD, 3'b100, 19'h00000, 16'h0000, 4'd11},  // R11 busy
      {K_WR, 3'b100, 19'h10001, 16'h00FF, 4'd11},  // R11 ignored write
      {K_WT, 3'b100, 19'h00000, 16'h0000, 4'd11},
      {K_RD, 3'b100, 19'h00000, 16'h0080, 4'd5},   // R5 status after op
      {K_RD, 3'b100, 19'h10001, 16'h0080, 4'd5},
      {K_WR, 3'b100, 19'h00000, 16'h00FF, 4'd3},
      {K_RD, 3'b100, 19'h10001, 16'h12F0, 4'd3},   // R3
      {K_WR, 3'b100, 19'h10001, 16'h0010, 4'd3},
      {K_WR, 3'b100, 19'h10001, 16'h0F0F, 4'd3},
      {K_WT, 3'b100, 19'h00000, 16'h0000, 4'd3},
      {K_WR, 3'b100, 19'h00000, 16'h00FF, 4'd3},
      {K_RD, 3'b100, 19'h10001, 16'h0200, 4'd3},   // R3 AND behaviour
      {K_WR, 3'b100, 19'h02001, 16'h0040, 4'd2},
      {K_WR, 3'b100, 19'h02001, 16'h5555, 4'd2},
      {K_WT, 3'b100, 19'h00000, 16'h0000, 4'd2},
      {K_WR, 3'b100, 19'h03001, 16'h0010, 4'd2},
      {K_WR, 3'b100, 19'h03001, 16'hAAAA, 4'd2},
      {K_WT, 3'b100, 19'h00000, 16'h0000, 4'd2},
      {K_WR, 3'b100, 19'h03000, 16'h0020, 4'd4},   // R4 erase second parameter block
      {K_WR, 3'b100, 19'h03000, 16'h00D0, 4'd4},
      {K_WT, 3'b100, 19'h00000, 16'h0000, 4'd4},
      {K_WR, 3'b100, 19'h00000, 16'h00FF, 4'd4},
      {K_RD, 3'b100, 19'h03001, 16'hFFFF, 4'd4},   // R4
      {K_RD, 3'b100, 19'h02001, 16'h5555, 4'd2},   // R2 neighbour untouched
      {K_WR, 3'b100, 19'h10000, 16'h0020, 4'd8},
      {K_WR, 3'b100, 19'h10000, 16'h00FF, 4'd8},   // R8 bad confirm
      {K_RD, 3'b100, 19'h00000, 16'h00B0, 4'd8},
      {K_WR, 3'b100, 19'h00000, 16'h0070, 4'd9},
      {K_RD, 3'b100, 19'h00000, 16'h00B0, 4'd9},   // R9 sticky
      {K_WR, 3'b100, 19'h00000, 16'h00FF, 4'd8},
      {K_RD, 3'b100, 19'h10001, 16'h0200, 4'd8},   // R8 nothing erased
      {K_WR, 3'b100, 19'h00000, 16'h0050, 4'd9},
      {K_WR, 3'b100, 19'h00000, 16'h0070, 4'd9},
      {K_RD, 3'b100, 19'h00000, 16'h0080, 4'd9},   // R9 cleared
      {K_WR, 3'b000, 19'h10002, 16'h0040, 4'd7},
      {K_WR, 3'b000, 19'h10002, 16'h1234, 4'd7},
      {K_RD, 3'b000, 19'h00000, 16'h0098, 4'd7},   // R7 program without voltage
      {K_WR, 3'b000, 19'h10000, 16'h0050, 4'd7},
      {K_WR, 3'b000, 19'h00000, 16'h0020, 4'd7},
      {K_WR, 3'b000, 19'h00000, 16'h00D0, 4'd7},
      {K_RD, 3'b000, 19'h00000, 16'h00A8, 4'd7},   // R7 erase without voltage
      {K_WR, 3'b100, 19'h00000, 16'h0050, 4'd7},
      {K_WR, 3'b100, 19'h00000, 16'h00FF, 4'd7},
      {K_RD, 3'b100, 19'h10002, 16'hFFFF, 4'd7},
      {K_WR, 3'b100, 19'h00001, 16'h0040, 4'd6},
      {K_WR, 3'b100, 19'h00001, 16'h00C3, 4'd6},
      {K_RD, 3'b100, 19'h00000, 16'h0090, 4'd6},   // R6 locked boot
      {K_WR, 3'b100, 19'h00000, 16'h0050, 4'd6},
      {K_WR, 3'b100, 19'h00000, 16'h00FF, 4'd6},
      {K_RD, 3'b100, 19'h00001, 16'hFFFF, 4'd6},
      {K_WR, 3'b110, 19'h00001, 16'h0040, 4'd6},
      {K_WR, 3'b110, 19'h00001, 16'h00C3, 4'd6},
      {K_WT, 3'b110, 19'h00000, 16'h0000, 4'd6},
      {K_RD, 3'b110, 19'h00000, 16'h0080, 4'd6},
      {K_WR, 3'b110, 19'h00000, 16'h00FF, 4'd6},
      {K_RD, 3'b110, 19'h00001, 16'h00C3, 4'd6},   // R6 unlocked program
      {K_WR, 3'b101, 19'h00000, 16'h0020, 4'd6},
      {K_WR, 3'b101, 19'h00000, 16'h00D0, 4'd6},
      {K_WT, 3'b101, 19'h00000, 16'h0000, 4'd6},
      {K_WR, 3'b101, 19'h00000, 16'h00FF, 4'd6},
      {K_RD, 3'b101, 19'h00001, 16'hFFFF, 4'd6},   // R6 erase via wp_release
      {K_WR, 3'b100, 19'h00000, 16'h0090, 4'd10},
      {K_RD, 3'b100, 19'h00000, MFG,      4'd10},  // R10
      {K_RD, 3'b100, 19'h00001, DEV_B,    4'd10},
      {K_WR, 3'b100, 19'h00000, 16'h0033, 4'd10},
      {K_RD, 3'b100, 19'h00001, DEV_B,    4'd10}   // R10 unknown command ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [18:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        boot_unlock = 1'b0, wp_release = 1'b0, vpp_ok = 1'b1;
   logic [15:0] rd_b, rd_t;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   bbf_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .boot_unlock(boot_unlock), .wp_release(wp_release),
      .vpp_ok(vpp_ok), .rd_data(rd_b));

   bbf_cmd_ctrl #(.TOP_BOOT(1'b1), .DEV_ID(DEV_T)) dut_t_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .boot_unlock(boot_unlock), .wp_release(wp_release),
      .vpp_ok(vpp_ok), .rd_data(rd_t));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [18:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [18:0] a, input logic [15:0] exp);
      bus_addr = a;
      #1;
      chk(tag, rd_b, exp);
   endtask

   task automatic wait_ready(input string tag);
      int n = 0;
      #1;
      while (!rd_b[7] && n < 64) begin
         @(negedge clk); #1; n++;
      end
      if (n >= 64) chk(tag, rd_b, 16'h0080);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         string tag;
         v = TBL[i];
         tag = $sformatf("R%0d vector %0d", v[3:0], i);
         {vpp_ok, boot_unlock, wp_release} = v[41:39];
         case (v[43:42])
            K_WR: wr(v[38:20], v[19:4]);
            K_RD: rd(tag, v[38:20], v[19:4]);
            default: wait_ready(tag);
         endcase
      end

      // R12: errors cleared and array selected by reset, contents kept
      vpp_ok = 1'b1; boot_unlock = 1'b0; wp_release = 1'b0;
      wr(19'h00000, 16'h0020);
      wr(19'h00000, 16'h0011);
      rd("R12 error before reset", 19'h0, 16'h00B0);
      do_reset();
      rd("R12 contents survive reset", 19'h10001, 16'h0200);
      wr(19'h00000, 16'h0070);
      rd("R1 status after reset", 19'h0, 16'h0080);

      // R11: busy lasts exactly BUSY cycles
      begin
         int n = 0;
         wr(19'h10003, 16'h0040);
         wr(19'h10003, 16'h7777);
         #1;
         while (!rd_b[7] && n < 64) begin
            n++; @(negedge clk); #1;
         end
         chk("R11 busy length", 16'(n), 16'(BUSY));
      end

      // R2: top-boot map mirrors the bottom-boot map
      do_reset();
      wr(19'h7E001, 16'h0040);
      wr(19'h7E001, 16'h00C3);
      #1;
      chk("R2 top-boot 7E001 is boot block", rd_t, 16'h0090);
      wait_ready("R2 bottom-boot wait");
      chk("R2 bottom-boot 7E001 is main block", rd_b, 16'h0080);
      wr(19'h00000, 16'h0050);
      wr(19'h7C001, 16'h0040);
      wr(19'h7C001, 16'h0F0F);
      wait_ready("R2 wait");
      repeat (2) @(negedge clk);
      wr(19'h00000, 16'h00FF);
      bus_addr = 19'h7C001; #1;
      chk("R2 top-boot parameter block programmed", rd_t, 16'h0F0F);
      chk("R2 bottom-boot 7C001 shares block with 7E001", rd_b, 16'h0003);
      bus_addr = 19'h7D001; #1;
      chk("R2 top-boot other parameter block untouched", rd_t, 16'hFFFF);
      bus_addr = 19'h00000; #1;
      chk("R2 top-boot main block at 00000 untouched", rd_t, 16'hFFFF);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule